// File: doc/BRIEF.md
# Delayed Receiver-Enable Scheduler

This block turns a receiver on at a chosen moment on a free-running, wrapping system time counter. Software writes a control word. If that word asks for a delayed start, the block arms and waits with the receiver off until the coarse part of the counter equals the programmed start time. If the word asks only for receive, the receiver turns on at once. The comparison ignores the low `IGN_W` bits of the counter.

At the moment the receiver turns on, the block starts two optional timeouts. The preamble timeout counts in units of `UNIT` clock cycles and is cancelled when a preamble is detected. The frame-wait timeout counts in clock cycles and is cancelled when the frame completes. Either expiry switches the receiver off and sets a sticky flag.

An arm request whose start time is already behind the counter is not rejected. The block waits for the counter to wrap round to the target, and it sets a sticky lateness flag so software can notice and recover. Software clears each flag by writing a one to its bit. A soft reset aborts any pending or active reception but keeps the flags.

Top module: `rx_delay_sched`

## Requirements
- R1: After `rst_n` is released, every output is 0.
- R2: In idle, a control write with `ctl_rx_en`=1 and `ctl_dly_en`=0 raises `rx_enable` from the next cycle.
- R3: In idle, a control write with `ctl_rx_en`=1 and `ctl_dly_en`=1 raises `armed` from the next cycle. `rx_enable` stays 0 until an edge at which `sys_time[TIME_W-1:IGN_W]` equals `start_time[TIME_W-1:IGN_W]`. From the cycle after that edge, `armed` is 0 and `rx_enable` is 1.
- R4: At arming, the block computes (target coarse − current coarse) modulo 2^(TIME_W−IGN_W). If the top bit of that value is set, `late_flag` (clear-mask bit 0) is set. The block still stays armed until the counter wraps round to the target.
- R5: If `pre_period` P is nonzero and `preamble_det` stays low, `rx_enable` stays high for exactly P×UNIT cycles after turn-on. At the end, `pre_to_flag` (clear-mask bit 1) sets and `pre_to_pulse` is high for one cycle. P=0 disables this timeout.
- R6: `preamble_det` while the preamble timeout runs cancels that timeout. A cancel in the same cycle as the expiry wins over the expiry.
- R7: If `fwt_en`=1 and `fwt_period` M is nonzero, and `frame_done` stays low, `rx_enable` stays high for exactly M cycles after turn-on. At the end, `fwt_to_flag` (clear-mask bit 2) sets and `fwt_to_pulse` is high for one cycle. With `fwt_en`=0 this timeout never fires.
- R8: `frame_done` while the receiver is on drops `rx_enable` the next cycle, cancels both timeouts and sets no flag.
- R9: `sts_clr_wr` clears every flag whose `sts_clr_mask` bit is 1. A flag being set in the same cycle stays set.
- R10: `soft_rst` returns the block to idle: it disarms, drops `rx_enable` and cancels the timeouts. It leaves all flags unchanged and overrides a simultaneous control write.
- R11: A control write while the block is armed or receiving has no effect.
- R12: Both timeouts are measured from the turn-on edge, not from the arm request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Abort to idle, flags kept |
| ctl_wr | input | 1 | Control write strobe |
| ctl_rx_en | input | 1 | Receive request bit of the control write |
| ctl_dly_en | input | 1 | Delayed-start bit of the control write |
| start_time | input | TIME_W (40) | Programmed turn-on time |
| sys_time | input | TIME_W (40) | Free-running system time |
| pre_period | input | PRE_W (16) | Preamble timeout in UNIT-cycle units, 0 = off |
| fwt_en | input | 1 | Frame-wait timeout enable |
| fwt_period | input | FWT_W (16) | Frame-wait timeout in cycles |
| preamble_det | input | 1 | Preamble detected |
| frame_done | input | 1 | Frame reception finished |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 3 | Write-one-to-clear mask: bit0 late, bit1 preamble, bit2 frame-wait |
| rx_enable | output | 1 | Receiver enable |
| armed | output | 1 | Waiting for the start time |
| late_flag | output | 1 | Sticky lateness flag |
| pre_to_flag | output | 1 | Sticky preamble-timeout flag |
| fwt_to_flag | output | 1 | Sticky frame-wait-timeout flag |
| pre_to_pulse | output | 1 | One-cycle preamble-timeout event |
| fwt_to_pulse | output | 1 | One-cycle frame-wait-timeout event |

## Verification
Every output comes from a register, so each result appears one edge after the inputs that cause it. `armed` and `rx_enable` respond to a control write, a coarse time match, `frame_done` or `soft_rst` one cycle later. A timeout flag and its pulse appear one cycle after the edge on which the count reaches its last unit: P×UNIT or M cycles after turn-on.

The bench drives inputs on falling edges and runs a behavioural model on each rising edge. It compares all seven outputs on the following falling edge. Duration checks count the falling edges on which `rx_enable` is high, and that count is exactly the period.

// File: rtl/rds_pkg.sv
package rds_pkg;
  typedef enum logic [1:0] {
    RDS_IDLE  = 2'd0,
    RDS_ARMED = 2'd1,
    RDS_ON    = 2'd2
  } rds_state_e;

  localparam int unsigned FLAG_LATE = 0;
  localparam int unsigned FLAG_PTO  = 1;
  localparam int unsigned FLAG_FWT  = 2;
  localparam int unsigned NFLAGS    = 3;
endpackage

// File: rtl/rds_time_cmp.sv
module rds_time_cmp #(
  parameter int unsigned TIME_W = 40,
  parameter int unsigned IGN_W  = 9
) (
  input  logic [TIME_W-1:0] sys_time,
  input  logic [TIME_W-1:0] start_time,
  output logic              at_target,
  output logic              behind
);
  localparam int unsigned HI_W = TIME_W - IGN_W;

  function automatic logic [HI_W-1:0] coarse(input logic [TIME_W-1:0] t);
    return t[TIME_W-1:IGN_W];
  endfunction

  // lead = target - now, modulo the coarse range; top bit set means target is behind
  function automatic logic lead_negative(input logic [HI_W-1:0] tgt,
                                         input logic [HI_W-1:0] now);
    logic [HI_W-1:0] lead;
    lead = tgt - now;
    return lead[HI_W-1];
  endfunction

  assign at_target = (coarse(sys_time) == coarse(start_time));
  assign behind    = lead_negative(coarse(start_time), coarse(sys_time));
endmodule

// File: rtl/rds_timeout.sv
module rds_timeout #(
  parameter int unsigned PER_W = 16,
  parameter int unsigned UNIT  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             start,
  input  logic             enable,
  input  logic [PER_W-1:0] period,
  input  logic             cancel,
  output logic             active,
  output logic             expire
);
  localparam int unsigned SH = $clog2(UNIT);
  localparam int unsigned CW = PER_W + SH;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  assign load_val = CW'(period) << SH;
  assign expire   = active && !cancel && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (kill) begin
      active <= 1'b0;
    end else if (start) begin
      active <= enable && (period != '0);
      cnt_q  <= load_val;
    end else if (active) begin
      if (cancel || expire) active <= 1'b0;
      else                  cnt_q  <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/rds_status.sv
module rds_status #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set[i] | (flags[i] & ~(clr_wr & clr_mask[i]));
    end
  end
endmodule

// File: rtl/rx_delay_sched.sv
module rx_delay_sched
  import rds_pkg::*;
#(
  parameter int unsigned TIME_W = 40,
  parameter int unsigned IGN_W  = 9,
  parameter int unsigned PRE_W  = 16,
  parameter int unsigned FWT_W  = 16,
  parameter int unsigned UNIT   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ctl_wr,
  input  logic              ctl_rx_en,
  input  logic              ctl_dly_en,
  input  logic [TIME_W-1:0] start_time,
  input  logic [TIME_W-1:0] sys_time,
  input  logic [PRE_W-1:0]  pre_period,
  input  logic              fwt_en,
  input  logic [FWT_W-1:0]  fwt_period,
  input  logic              preamble_det,
  input  logic              frame_done,
  input  logic              sts_clr_wr,
  input  logic [2:0]        sts_clr_mask,
  output logic              rx_enable,
  output logic              armed,
  output logic              late_flag,
  output logic              pre_to_flag,
  output logic              fwt_to_flag,
  output logic              pre_to_pulse,
  output logic              fwt_to_pulse
);
  rds_state_e state_q, state_d;

  // named internal events
  logic at_target, behind;
  logic is_idle, is_armed, is_on;
  logic arm_req, turn_on, rx_leave, timer_kill, late_evt;
  logic pre_active, pre_exp, fwt_active, fwt_exp;
  logic pre_exp_ok, fwt_exp_ok;
  logic [NFLAGS-1:0] flag_set, flag_q;

  rds_time_cmp #(.TIME_W(TIME_W), .IGN_W(IGN_W)) u_cmp (
    .sys_time  (sys_time),
    .start_time(start_time),
    .at_target (at_target),
    .behind    (behind)
  );

  assign is_idle  = (state_q == RDS_IDLE);
  assign is_armed = (state_q == RDS_ARMED);
  assign is_on    = (state_q == RDS_ON);

  assign arm_req    = !soft_rst && is_idle && ctl_wr && ctl_rx_en && ctl_dly_en;
  assign turn_on    = !soft_rst && ((is_armed && at_target) ||
                                    (is_idle && ctl_wr && ctl_rx_en && !ctl_dly_en));
  assign rx_leave   = is_on && (pre_exp || fwt_exp || frame_done);
  assign timer_kill = soft_rst || rx_leave;
  assign late_evt   = arm_req && behind;
  assign pre_exp_ok = pre_exp && !soft_rst;
  assign fwt_exp_ok = fwt_exp && !soft_rst;

  rds_timeout #(.PER_W(PRE_W), .UNIT(UNIT)) u_pre_to (
    .clk   (clk),
    .rst_n (rst_n),
    .kill  (timer_kill),
    .start (turn_on),
    .enable(1'b1),
    .period(pre_period),
    .cancel(preamble_det),
    .active(pre_active),
    .expire(pre_exp)
  );

  rds_timeout #(.PER_W(FWT_W), .UNIT(1)) u_fwt_to (
    .clk   (clk),
    .rst_n (rst_n),
    .kill  (timer_kill),
    .start (turn_on),
    .enable(fwt_en),
    .period(fwt_period),
    .cancel(frame_done),
    .active(fwt_active),
    .expire(fwt_exp)
  );

  always_comb begin
    state_d = state_q;
    if (soft_rst)      state_d = RDS_IDLE;
    else if (turn_on)  state_d = RDS_ON;
    else if (arm_req)  state_d = RDS_ARMED;
    else if (rx_leave) state_d = RDS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= RDS_IDLE;
      pre_to_pulse <= 1'b0;
      fwt_to_pulse <= 1'b0;
    end else begin
      state_q      <= state_d;
      pre_to_pulse <= pre_exp_ok;
      fwt_to_pulse <= fwt_exp_ok;
    end
  end

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_LATE] = late_evt;
    flag_set[FLAG_PTO]  = pre_exp_ok;
    flag_set[FLAG_FWT]  = fwt_exp_ok;
  end

  rds_status #(.N(NFLAGS)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (flag_set),
    .clr_wr  (sts_clr_wr),
    .clr_mask(sts_clr_mask),
    .flags   (flag_q)
  );

  assign rx_enable   = is_on;
  assign armed       = is_armed;
  assign late_flag   = flag_q[FLAG_LATE];
  assign pre_to_flag = flag_q[FLAG_PTO];
  assign fwt_to_flag = flag_q[FLAG_FWT];
endmodule

// File: rtl/rds_checker.sv
module rds_checker (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic sts_clr_wr,
  input logic at_target,
  input logic frame_done,
  input logic rx_enable,
  input logic armed,
  input logic late_flag,
  input logic pre_to_flag,
  input logic fwt_to_flag,
  input logic pre_to_pulse,
  input logic fwt_to_pulse
);
  assert_one_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_enable, armed}));

  assert_hold_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !at_target && !soft_rst |=> armed && !rx_enable);

  assert_turn_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && at_target && !soft_rst |=> rx_enable);

  assert_pre_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_to_pulse |-> pre_to_flag && !rx_enable);

  assert_fwt_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwt_to_pulse |-> fwt_to_flag && !rx_enable);

  assert_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && frame_done && !soft_rst |=> !rx_enable);

  assert_soft_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !rx_enable && !armed);

  assert_soft_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !sts_clr_wr |=> $stable({late_flag, pre_to_flag, fwt_to_flag}));
endmodule

bind rx_delay_sched rds_checker u_rds_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .sts_clr_wr  (sts_clr_wr),
  .at_target   (at_target),
  .frame_done  (frame_done),
  .rx_enable   (rx_enable),
  .armed       (armed),
  .late_flag   (late_flag),
  .pre_to_flag (pre_to_flag),
  .fwt_to_flag (fwt_to_flag),
  .pre_to_pulse(pre_to_pulse),
  .fwt_to_pulse(fwt_to_pulse)
);

// File: tb/rx_delay_sched_tb.sv
`timescale 1ns/1ps
module rx_delay_sched_tb_top;
  localparam int TW = 16, IG = 4, PW = 8, FW = 12, UN = 8;
  localparam int HI = TW - IG;
  localparam int WD = 150000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, soft_rst = 1'b0, ctl_wr = 1'b0, ctl_rx_en = 1'b0, ctl_dly_en = 1'b0;
  logic [TW-1:0] start_time = '0, tcnt = '0, tofs = '0, sys_time;
  logic [PW-1:0] pre_period = '0;
  logic fwt_en = 1'b0;
  logic [FW-1:0] fwt_period = '0;
  logic preamble_det = 1'b0, frame_done = 1'b0, sts_clr_wr = 1'b0;
  logic [2:0] sts_clr_mask = '0;
  logic rx_enable, armed, late_flag, pre_to_flag, fwt_to_flag, pre_to_pulse, fwt_to_pulse;

  assign sys_time = tcnt + tofs;
  always @(posedge clk) tcnt <= tcnt + 1'b1;

  rx_delay_sched #(.TIME_W(TW), .IGN_W(IG), .PRE_W(PW), .FWT_W(FW), .UNIT(UN)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctl_wr(ctl_wr), .ctl_rx_en(ctl_rx_en),
    .ctl_dly_en(ctl_dly_en), .start_time(start_time), .sys_time(sys_time),
    .pre_period(pre_period), .fwt_en(fwt_en), .fwt_period(fwt_period),
    .preamble_det(preamble_det), .frame_done(frame_done), .sts_clr_wr(sts_clr_wr),
    .sts_clr_mask(sts_clr_mask), .rx_enable(rx_enable), .armed(armed),
    .late_flag(late_flag), .pre_to_flag(pre_to_flag), .fwt_to_flag(fwt_to_flag),
    .pre_to_pulse(pre_to_pulse), .fwt_to_pulse(fwt_to_pulse));

  int checks = 0, errors = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  int m_mode = 0;          // 0 idle, 1 waiting, 2 receiving
  int pre_left = 0, fwt_left = 0;
  bit m_late = 0, m_pto = 0, m_fwt = 0, m_pp = 0, m_fp = 0;

  function automatic bit is_behind(int tgt, int now);
    int span, a, b, d;
    span = 1 << HI;
    a = tgt >> IG; b = now >> IG;
    d = (a - b + span) % span;
    return d >= span / 2;
  endfunction

  always @(posedge clk) begin
    bit pe, fe, ls, go;
    pe = 0; fe = 0; ls = 0; go = 0;
    if (!rst_n) begin
      m_mode = 0; pre_left = 0; fwt_left = 0;
      m_late = 0; m_pto = 0; m_fwt = 0; m_pp = 0; m_fp = 0;
    end else begin
      if (soft_rst) begin
        m_mode = 0; pre_left = 0; fwt_left = 0;
      end else if (m_mode == 0) begin
        if (ctl_wr && ctl_rx_en) begin
          if (ctl_dly_en) begin
            m_mode = 1;
            ls = is_behind(int'(start_time), int'(sys_time));
          end else go = 1;
        end
      end else if (m_mode == 1) begin
        if ((int'(sys_time) >> IG) == (int'(start_time) >> IG)) go = 1;
      end else begin
        if (pre_left > 0) begin
          if (preamble_det) pre_left = 0;
          else if (pre_left == 1) pe = 1;
          else pre_left--;
        end
        if (fwt_left > 0) begin
          if (frame_done) fwt_left = 0;
          else if (fwt_left == 1) fe = 1;
          else fwt_left--;
        end
        if (pe || fe || frame_done) begin
          m_mode = 0; pre_left = 0; fwt_left = 0;
        end
      end
      if (go) begin
        m_mode = 2;
        pre_left = int'(pre_period) * UN;
        fwt_left = fwt_en ? int'(fwt_period) : 0;
      end
      if (sts_clr_wr) begin
        if (sts_clr_mask[0]) m_late = 0;
        if (sts_clr_mask[1]) m_pto = 0;
        if (sts_clr_mask[2]) m_fwt = 0;
      end
      if (ls) m_late = 1;
      if (pe) m_pto = 1;
      if (fe) m_fwt = 1;
      m_pp = pe; m_fp = fe;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [6:0] got, exp;
      got = {rx_enable, armed, late_flag, pre_to_flag, fwt_to_flag, pre_to_pulse, fwt_to_pulse};
      exp = {m_mode == 2, m_mode == 1, m_late, m_pto, m_fwt, m_pp, m_fp};
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s model compare t=%0t actual=%b expected=%b", phase, $time, got, exp);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(bit rx, bit dly);
    ctl_wr = 1; ctl_rx_en = rx; ctl_dly_en = dly;
    tick();
    ctl_wr = 0; ctl_rx_en = 0; ctl_dly_en = 0;
  endtask

  task automatic clr(logic [2:0] m);
    sts_clr_wr = 1; sts_clr_mask = m;
    tick();
    sts_clr_wr = 0; sts_clr_mask = '0;
  endtask

  task automatic end_frame();
    frame_done = 1; tick(); frame_done = 0;
  endtask

  task automatic on_len(output int n);
    n = 0;
    while (rx_enable && n < 2000) begin n++; tick(); end
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD);
      summary();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    repeat (4) tick();
    rst_n = 1;
    tick();
    phase = "R1";
    chk("R1 outputs", int'({rx_enable, armed, late_flag, pre_to_flag, fwt_to_flag,
                            pre_to_pulse, fwt_to_pulse}), 0);

    // immediate start, then frame end
    phase = "R2";
    wr_ctl(1, 0);
    chk("R2 rx_enable", rx_enable, 1);
    repeat (5) tick();
    phase = "R8";
    end_frame();
    chk("R8 rx_enable", rx_enable, 0);
    chk("R8 flags", int'({pre_to_flag, fwt_to_flag}), 0);

    // delayed start, ignored write, preamble timeout from turn-on
    phase = "R3";
    pre_period = 2;
    start_time = sys_time + 16'd80;
    wr_ctl(1, 1);
    chk("R3 armed", armed, 1);
    chk("R3 rx_enable off", rx_enable, 0);
    chk("R4 no late", late_flag, 0);
    phase = "R11";
    repeat (3) tick();
    wr_ctl(1, 0);
    chk("R11 still armed", armed, 1);
    chk("R11 rx_enable", rx_enable, 0);
    phase = "R3";
    n = 0;
    while (!rx_enable && n < 200) begin n++; tick(); end
    chk("R3 turned on", rx_enable, 1);
    chk("R3 wait in range", int'(n >= 50 && n <= 96), 1);
    phase = "R12";
    on_len(n);
    chk("R12 R5 on length", n, 2 * UN);
    chk("R5 pre flag", pre_to_flag, 1);

    // preamble cancel, frame-wait expiry
    phase = "R6";
    pre_period = 3; fwt_en = 1; fwt_period = 40;
    wr_ctl(1, 0);
    preamble_det = 1;
    on_len(n);
    preamble_det = 0;
    chk("R6 R7 on length", n, 40);
    chk("R7 fwt flag", fwt_to_flag, 1);

    // W1C clear
    phase = "R9";
    clr(3'b110);
    chk("R9 cleared", int'({pre_to_flag, fwt_to_flag}), 0);

    // frame-wait disabled
    phase = "R7";
    pre_period = 0; fwt_en = 0;
    wr_ctl(1, 0);
    repeat (100) tick();
    chk("R7 disabled stays on", rx_enable, 1);
    end_frame();
    chk("R7 no fwt flag", fwt_to_flag, 0);

    // set wins over clear in same cycle
    phase = "R9";
    fwt_en = 1; fwt_period = 4;
    wr_ctl(1, 0);
    repeat (3) tick();
    sts_clr_wr = 1; sts_clr_mask = 3'b100;
    tick();
    sts_clr_wr = 0; sts_clr_mask = '0;
    chk("R9 set beats clear", fwt_to_flag, 1);
    chk("R7 off after expiry", rx_enable, 0);
    clr(3'b100);
    chk("R9 clear after", fwt_to_flag, 0);

    // late arm, wrap wait
    phase = "R4";
    fwt_en = 0; pre_period = 0;
    start_time = sys_time - 16'd48;
    wr_ctl(1, 1);
    chk("R4 late flag", late_flag, 1);
    repeat (100) tick();
    chk("R4 still armed", armed, 1);
    chk("R4 not on", rx_enable, 0);
    tofs = tofs + ((((start_time >> IG) - 16'd1) << IG) - sys_time);
    n = 0;
    while (!rx_enable && n < 64) begin n++; tick(); end
    chk("R4 on after wrap", rx_enable, 1);
    end_frame();

    // soft reset
    phase = "R10";
    pre_period = 2;
    wr_ctl(1, 0);
    repeat (3) tick();
    soft_rst = 1; tick(); soft_rst = 0;
    chk("R10 off", rx_enable, 0);
    repeat (30) tick();
    chk("R10 no pre flag", pre_to_flag, 0);
    chk("R10 late kept", late_flag, 1);
    start_time = sys_time + 16'd200;
    wr_ctl(1, 1);
    soft_rst = 1; ctl_wr = 1; ctl_rx_en = 1; ctl_dly_en = 1;
    tick();
    soft_rst = 0; ctl_wr = 0; ctl_rx_en = 0; ctl_dly_en = 0;
    chk("R10 disarmed", armed, 0);
    chk("R10 write overridden", rx_enable, 0);
    repeat (5) tick();
    summary();
  end
endmodule